// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block presents interrupts to one processor. It keeps three pieces of state. The first is a 32-bit presentation word: its upper byte is the processor's current priority and its lower 24 bits name the source now on offer. The second is a latched priority for that offered source. The third is an inter-processor-interrupt (IPI) priority that software can program. A numerically smaller priority is more favoured. A source number of zero means that nothing is on offer.

The source layer sends presentation requests, each a source number with a priority. The controller either takes the request or bounces it back with a one-cycle reject pulse. When a more favoured source displaces one that is already on offer, the displaced source is rejected. The processor works the block through a register port with five operations: change the current priority, program the IPI priority, accept (read and acknowledge), end-of-interrupt (EOI) and poll. An EOI is forwarded to the source layer. When the processor can take more work, the controller asks the source layer to resend. The IPI competes in the same slot as external sources and is always offered as source number 2.

Top module: `pic_presenter`

## Requirements
- R1: After a synchronous active-low reset, the presentation word is 0, the latched priority is 0xFF, the IPI priority is 0xFF and `irq_out` is low.
- R2: A request whose priority is greater than or equal to the current priority is rejected. `rej_valid` pulses with that source number, and the offered source and `irq_out` are left unchanged.
- R3: A request is also rejected when a source is already on offer whose latched priority is less than or equal to the new priority.
- R4: A request that is not rejected first rejects any source already on offer. It then latches its own number and priority and raises `irq_out`. `irq_out` is high exactly when the offered source number is non-zero.
- R5: Accept (op code 2) returns the presentation word as it was before the operation, together with the IPI priority, and lowers `irq_out`. The current priority takes the latched priority, the offered source becomes 0 and the latched priority becomes 0xFF.
- R6: Set-priority (op code 0, new value in `op_wdata[7:0]`) to a smaller value withdraws an offered source if the new value is less than or equal to that source's latched priority. The withdrawal clears the source, sets the latched priority to 0xFF, lowers `irq_out` and rejects the source. A smaller value that does not meet this condition only updates the priority and sends no resend.
- R7: Set-priority to an equal or larger value while nothing is on offer pulses `resend_valid`. If the IPI priority is below the new current priority, the IPI check also runs.
- R8: Set-IPI (op code 1, value in `op_wdata[7:0]`) stores the IPI priority. If that value is below the current priority, the IPI check runs. The check does nothing if an offered source has a latched priority less than or equal to the IPI priority. Otherwise it rejects any offered source, offers source 2 at the IPI priority and raises `irq_out`.
- R9: EOI (op code 3) loads the current priority from `op_wdata[31:24]` and pulses `eoi_valid` with `op_wdata[23:0]`. If nothing is on offer, a resend follows, as in R7.
- R10: Poll (op code 4) returns the presentation word and the IPI priority and changes no state.
- R11: In a cycle where `op_valid` is high, a request is dropped: it is neither latched nor rejected. Op codes 5 to 7 have no effect. All outputs are registered and appear one clock after the operation or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 3 | 0 set priority, 1 set IPI, 2 accept, 3 EOI, 4 poll |
| op_wdata | input | 32 | Operation write data |
| req_valid | input | 1 | Presentation request from the source layer |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requesting priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read data valid (accept or poll) |
| rd_word | output | 32 | Presentation word returned |
| rd_ipi | output | 8 | IPI priority returned |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | EOI pulse to the source layer |
| eoi_src | output | 24 | Source number ending service |
| resend_valid | output | 1 | Resend request pulse to the source layer |

## Verification
Requests are tried in four situations: against a masking current priority, including the case of equal priority; against an offered source of equal priority; against an offered source of worse priority; and in the same cycle as an operation. Together these tell a plain reject, a tie reject, a displacement with a reject of the old source and a dropped request apart. Priority writes are tried downward with and without withdrawal, including the equal boundary, and upward or equal with nothing on offer. This separates a withdrawal, a silent update and a resend. EOI and IPI writes are tried with a source on offer and with none, so that the bench can tell when the IPI takes the slot, when it loses it to an external source and when a resend occurs.

// File: rtl/pic_pkg.sv
// Shared widths, op codes and state types for the presentation controller.
// Assumes an 8-bit priority and a 24-bit source number; a smaller priority wins.
package pic_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int REG_W  = PRIO_W + SRC_W;
    localparam int OPC_W  = 3;

    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    localparam logic [OPC_W-1:0] OPC_SET_PRIO = 3'd0;
    localparam logic [OPC_W-1:0] OPC_SET_IPI  = 3'd1;
    localparam logic [OPC_W-1:0] OPC_ACCEPT   = 3'd2;
    localparam logic [OPC_W-1:0] OPC_EOI      = 3'd3;
    localparam logic [OPC_W-1:0] OPC_POLL     = 3'd4;

    typedef struct packed {
        logic [PRIO_W-1:0] cur_prio;
        logic [SRC_W-1:0]  pend_src;
        logic [PRIO_W-1:0] pend_prio;
        logic [PRIO_W-1:0] ipi_prio;
        logic              irq;
    } core_t;

    typedef struct packed {
        logic              rej;
        logic [SRC_W-1:0]  rej_src;
        logic              eoi;
        logic [SRC_W-1:0]  eoi_src;
        logic              resend;
        logic              rd;
        logic [REG_W-1:0]  rd_word;
        logic [PRIO_W-1:0] rd_ipi;
    } note_t;
endpackage

// File: rtl/pic_decide.sv
// Next-state and notification logic of the presentation controller.
// Purely combinational. At most one operation or request is handled per cycle,
// and an operation wins. At most one reject can arise from any single event.
module pic_decide
    import pic_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SOURCE = 24'd2
) (
    input  core_t              cur,
    input  logic               op_valid,
    input  logic [OPC_W-1:0]   op_code,
    input  logic [REG_W-1:0]   op_wdata,
    input  logic               req_valid,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [PRIO_W-1:0]  req_prio,
    output core_t              nxt,
    output note_t              note
);
    logic              busy;
    logic [PRIO_W-1:0] wr_lo;
    logic [PRIO_W-1:0] wr_hi;
    logic              run_ipi;

    assign busy  = (cur.pend_src != '0);
    assign wr_lo = op_wdata[PRIO_W-1:0];
    assign wr_hi = op_wdata[REG_W-1:SRC_W];

    // Decide the next state, pulses and read data for this cycle.
    always_comb begin
        nxt     = cur;
        note    = '0;
        run_ipi = 1'b0;
        if (op_valid) begin
            case (op_code)
                OPC_SET_PRIO: begin
                    nxt.cur_prio = wr_lo;
                    if (wr_lo < cur.cur_prio) begin
                        if (busy && (wr_lo <= cur.pend_prio)) begin
                            nxt.pend_src  = '0;
                            nxt.pend_prio = PRIO_NONE;
                            nxt.irq       = 1'b0;
                            note.rej      = 1'b1;
                            note.rej_src  = cur.pend_src;
                        end
                    end else if (!busy) begin
                        note.resend = 1'b1;
                        run_ipi     = (cur.ipi_prio < wr_lo);
                    end
                end
                OPC_SET_IPI: begin
                    nxt.ipi_prio = wr_lo;
                    run_ipi      = (wr_lo < cur.cur_prio);
                end
                OPC_ACCEPT: begin
                    note.rd       = 1'b1;
                    note.rd_word  = {cur.cur_prio, cur.pend_src};
                    note.rd_ipi   = cur.ipi_prio;
                    nxt.irq       = 1'b0;
                    nxt.cur_prio  = cur.pend_prio;
                    nxt.pend_src  = '0;
                    nxt.pend_prio = PRIO_NONE;
                end
                OPC_EOI: begin
                    nxt.cur_prio = wr_hi;
                    note.eoi     = 1'b1;
                    note.eoi_src = op_wdata[SRC_W-1:0];
                    if (!busy) begin
                        note.resend = 1'b1;
                        run_ipi     = (cur.ipi_prio < wr_hi);
                    end
                end
                OPC_POLL: begin
                    note.rd      = 1'b1;
                    note.rd_word = {cur.cur_prio, cur.pend_src};
                    note.rd_ipi  = cur.ipi_prio;
                end
                default: ;
            endcase
        end else if (req_valid) begin
            if ((req_prio >= cur.cur_prio) || (busy && (cur.pend_prio <= req_prio))) begin
                note.rej     = 1'b1;
                note.rej_src = req_src;
            end else begin
                if (busy) begin
                    note.rej     = 1'b1;
                    note.rej_src = cur.pend_src;
                end
                nxt.pend_src  = req_src;
                nxt.pend_prio = req_prio;
                nxt.irq       = 1'b1;
            end
        end
        // IPI check: offer the IPI unless an equal or better source already holds the slot.
        if (run_ipi && !(busy && (cur.pend_prio <= nxt.ipi_prio))) begin
            if (busy) begin
                note.rej     = 1'b1;
                note.rej_src = cur.pend_src;
            end
            nxt.pend_src  = IPI_SOURCE;
            nxt.pend_prio = nxt.ipi_prio;
            nxt.irq       = 1'b1;
        end
    end
endmodule

// File: rtl/pic_state.sv
// State and output registers of the presentation controller.
// Synchronous active-low reset; every output of the block leaves a flop here.
module pic_state
    import pic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  core_t nxt,
    input  note_t note,
    output core_t cur,
    output note_t note_q
);
    localparam core_t CORE_RESET = '{
        cur_prio:  '0,
        pend_src:  '0,
        pend_prio: PRIO_NONE,
        ipi_prio:  PRIO_NONE,
        irq:       1'b0
    };

    // Hold the presentation state across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= CORE_RESET;
        else        cur <= nxt;
    end

    // Register the one-cycle notifications and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) note_q <= '0;
        else        note_q <= note;
    end
endmodule

// File: rtl/pic_presenter.sv
// Per-processor interrupt presentation controller (top).
// Takes requests from a source layer and register operations from the
// processor, and drives one interrupt line. Assumes the source layer never
// requests with source number 0 and retries any request dropped under an operation.
module pic_presenter
    import pic_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SOURCE = 24'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [REG_W-1:0]  op_wdata,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              irq_out,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_word,
    output logic [PRIO_W-1:0] rd_ipi,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_valid
);
    core_t cur;
    core_t nxt;
    note_t note;
    note_t note_q;

    pic_decide #(.IPI_SOURCE(IPI_SOURCE)) u_decide (
        .cur       (cur),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_wdata  (op_wdata),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_prio  (req_prio),
        .nxt       (nxt),
        .note      (note)
    );

    pic_state u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt    (nxt),
        .note   (note),
        .cur    (cur),
        .note_q (note_q)
    );

    assign irq_out      = cur.irq;
    assign rd_valid     = note_q.rd;
    assign rd_word      = note_q.rd_word;
    assign rd_ipi       = note_q.rd_ipi;
    assign rej_valid    = note_q.rej;
    assign rej_src      = note_q.rej_src;
    assign eoi_valid    = note_q.eoi;
    assign eoi_src      = note_q.eoi_src;
    assign resend_valid = note_q.resend;

    // R4: the line is high exactly while a source is on offer.
    a_r4_irq_matches_offer: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (cur.pend_src != '0));

    // R5: an empty slot always carries the idle latched priority.
    a_r5_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.pend_src == '0) |-> (cur.pend_prio == PRIO_NONE));

    // R2: a masked request bounces back with its own number.
    a_r2_masked_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op_valid && (req_prio >= cur.cur_prio))
        |=> (rej_valid && (rej_src == $past(req_src))));

    // R5: accept returns the old word and empties the slot.
    a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OPC_ACCEPT))
        |=> (!irq_out && (cur.pend_src == '0) && rd_valid
             && (rd_word == {$past(cur.cur_prio), $past(cur.pend_src)})));

    // R9: EOI forwards the low field and loads the priority from the top byte.
    a_r9_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OPC_EOI))
        |=> (eoi_valid && (eoi_src == $past(op_wdata[SRC_W-1:0]))
             && (cur.cur_prio == $past(op_wdata[REG_W-1:SRC_W]))));

    // R10: poll leaves every piece of state untouched.
    a_r10_poll_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OPC_POLL))
        |=> ($stable(cur) && !rej_valid && !resend_valid));
endmodule

// File: tb/pic_presenter_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs of each cycle into
// a queue; the monitor pops and compares them one clock later, away from the edge.
module pic_presenter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] op_wdata = 32'd0;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = 24'd0;
    logic [7:0]  req_prio = 8'd0;
    logic        irq_out, rd_valid, rej_valid, eoi_valid, resend_valid;
    logic [31:0] rd_word;
    logic [7:0]  rd_ipi;
    logic [23:0] rej_src, eoi_src;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic        irq;
        logic        rej;
        logic [23:0] rsrc;
        logic        eoi;
        logic [23:0] esrc;
        logic        rs;
        logic        rd;
        logic [31:0] rword;
        logic [7:0]  ripi;
        string       tag;
    } exp_t;

    exp_t sb[$];

    pic_presenter uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_wdata(op_wdata), .req_valid(req_valid), .req_src(req_src),
        .req_prio(req_prio), .irq_out(irq_out), .rd_valid(rd_valid),
        .rd_word(rd_word), .rd_ipi(rd_ipi), .rej_valid(rej_valid),
        .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_valid(resend_valid)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t ex(logic irq, logic rej, logic [23:0] rsrc, logic eoi,
                                logic [23:0] esrc, logic rs, logic rd,
                                logic [31:0] rword, logic [7:0] ripi, string tag);
        exp_t e;
        e.due = 0; e.irq = irq; e.rej = rej; e.rsrc = rsrc; e.eoi = eoi;
        e.esrc = esrc; e.rs = rs; e.rd = rd; e.rword = rword; e.ripi = ripi; e.tag = tag;
        return e;
    endfunction

    // Driver: apply one cycle of stimulus and queue what must appear after the next edge.
    task automatic drive(input logic ov, input logic [2:0] oc, input logic [31:0] wd,
                         input logic rv, input logic [23:0] rs, input logic [7:0] rp,
                         input exp_t e);
        op_valid = ov; op_code = oc; op_wdata = wd;
        req_valid = rv; req_src = rs; req_prio = rp;
        e.due = cyc + 1;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic op(input logic [2:0] oc, input logic [31:0] wd, input exp_t e);
        drive(1'b1, oc, wd, 1'b0, 24'd0, 8'd0, e);
    endtask

    task automatic req(input logic [23:0] s, input logic [7:0] p, input exp_t e);
        drive(1'b0, 3'd0, 32'd0, 1'b1, s, p, e);
    endtask

    // Monitor: compare every due expectation against the ports between edges.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic bad;
            e = sb.pop_front();
            checks++;
            bad = (irq_out !== e.irq) || (rej_valid !== e.rej)
               || (e.rej && rej_src !== e.rsrc) || (eoi_valid !== e.eoi)
               || (e.eoi && eoi_src !== e.esrc) || (resend_valid !== e.rs)
               || (rd_valid !== e.rd) || (e.rd && (rd_word !== e.rword || rd_ipi !== e.ripi));
            if (bad) begin
                failures++;
                $display("FAIL %s: got irq=%b rej=%b/%h eoi=%b/%h rs=%b rd=%b/%h/%h exp irq=%b rej=%b/%h eoi=%b/%h rs=%b rd=%b/%h/%h",
                         e.tag, irq_out, rej_valid, rej_src, eoi_valid, eoi_src, resend_valid,
                         rd_valid, rd_word, rd_ipi, e.irq, e.rej, e.rsrc, e.eoi, e.esrc,
                         e.rs, e.rd, e.rword, e.ripi);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 3000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got cycle=%0d exp finish before 3000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, seen through poll (R10)
        op(3'd4, 32'd0, ex(0,0,0,0,0,0,1,32'h00000000,8'hFF,"R1 reset poll"));
        // R2 request against current priority 0
        req(24'h5, 8'h3, ex(0,1,24'h5,0,0,0,0,0,0,"R2 masked by prio 0"));
        // R7 raise priority with nothing on offer -> resend
        op(3'd0, 32'h10, ex(0,0,0,0,0,1,0,0,0,"R7 resend on raise"));
        // R4 take a request
        req(24'h7, 8'h8, ex(1,0,0,0,0,0,0,0,0,"R4 latch first"));
        // R3 equal priority tie loses
        req(24'h9, 8'h8, ex(1,1,24'h9,0,0,0,0,0,0,"R3 tie rejected"));
        // R4 better request displaces old
        req(24'hA, 8'h4, ex(1,1,24'h7,0,0,0,0,0,0,"R4 displace rejects old"));
        op(3'd4, 32'd0, ex(1,0,0,0,0,0,1,32'h1000000A,8'hFF,"R10 poll word"));
        // R11 request under an operation is dropped
        drive(1'b1, 3'd4, 32'd0, 1'b1, 24'hB, 8'h1,
              ex(1,0,0,0,0,0,1,32'h1000000A,8'hFF,"R11 request dropped"));
        // R11 unused op code
        op(3'd6, 32'h0, ex(1,0,0,0,0,0,0,0,0,"R11 unused op"));
        // R5 accept
        op(3'd2, 32'd0, ex(0,0,0,0,0,0,1,32'h1000000A,8'hFF,"R5 accept old word"));
        op(3'd4, 32'd0, ex(0,0,0,0,0,0,1,32'h04000000,8'hFF,"R5 prio loaded"));
        // R8 IPI below priority with empty slot
        op(3'd1, 32'h2, ex(1,0,0,0,0,0,0,0,0,"R8 ipi offered"));
        op(3'd1, 32'h3, ex(1,0,0,0,0,0,0,0,0,"R8 ipi check keeps better"));
        op(3'd4, 32'd0, ex(1,0,0,0,0,0,1,32'h04000002,8'h03,"R8 ipi word"));
        // R4 external source displaces the IPI
        req(24'hC, 8'h1, ex(1,1,24'h2,0,0,0,0,0,0,"R4 displace ipi"));
        // R6 lower priority onto the offered priority -> withdraw
        op(3'd0, 32'h1, ex(0,1,24'hC,0,0,0,0,0,0,"R6 withdraw"));
        op(3'd4, 32'd0, ex(0,0,0,0,0,0,1,32'h01000000,8'h03,"R6 slot empty"));
        // R9 EOI with empty slot -> resend and IPI check
        op(3'd3, 32'hFF00000C, ex(1,0,0,1,24'hC,1,0,0,0,"R9 eoi resend"));
        op(3'd4, 32'd0, ex(1,0,0,0,0,0,1,32'hFF000002,8'h03,"R9 ipi after eoi"));
        op(3'd2, 32'd0, ex(0,0,0,0,0,0,1,32'hFF000002,8'h03,"R5 accept ipi"));
        // R6 smaller value, nothing on offer -> silent
        op(3'd0, 32'h2, ex(0,0,0,0,0,0,0,0,0,"R6 silent lower"));
        // R7 equal value, nothing on offer -> resend, IPI not below
        op(3'd0, 32'h2, ex(0,0,0,0,0,1,0,0,0,"R7 resend on equal"));
        op(3'd1, 32'hFF, ex(0,0,0,0,0,0,0,0,0,"R8 ipi idle"));
        op(3'd3, 32'h05000011, ex(0,0,0,1,24'h11,1,0,0,0,"R9 eoi empty"));
        // R2 boundary: priority equal to current
        req(24'h20, 8'h5, ex(0,1,24'h20,0,0,0,0,0,0,"R2 equal boundary"));
        req(24'h21, 8'h4, ex(1,0,0,0,0,0,0,0,0,"R4 latch again"));
        // R9 EOI while busy: no resend
        op(3'd3, 32'h06000003, ex(1,0,0,1,24'h3,0,0,0,0,"R9 eoi busy"));
        // R6 lower to exactly the offered priority
        op(3'd0, 32'h4, ex(0,1,24'h21,0,0,0,0,0,0,"R6 withdraw boundary"));
        op(3'd4, 32'd0, ex(0,0,0,0,0,0,1,32'h04000000,8'hFF,"R10 final poll"));
        op_valid = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: got %0d items left exp 0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule